// File: doc/BRIEF.md
# Virtual UART Line Status Logic

This block produces the 8-bit line status byte of an emulated 16550-style serial port. No physical serial line exists. A host and embedded firmware trade bytes through two small queues. Host writes to the transmit holding location go into a transmit queue, and firmware drains that queue. Firmware writes to the receive buffer go into a receive queue, and the host drains that queue. In FIFO mode each queue holds up to `DEPTH` bytes. In non-FIFO mode each queue acts as a single holding register.

The status byte sits at host offset 5h. Data-ready and transmit-empty follow the occupancy of the queues. Overrun and break are sticky flags. Firmware raises them with set requests, and a host read of the status byte clears them. Both sides reach their registers through a simple strobe bus. The host read data is combinational from the address, so a status read returns the value the byte had before the clear.

Register maps. Host side:
- Offset 0: a read takes from the receive queue; a write goes into the transmit queue.
- Offset 2: a write to bit 0 selects the mode (1 = FIFO).
- Offset 5: a read returns the status byte.

Firmware side:
- Offset 0: a write goes into the receive queue; a read takes from the transmit queue.
- Offset 1: control. Bit 0 is the transmit-holding enable, which is stored. Bit 1 requests overrun. Bit 2 requests break in FIFO mode. Bit 3 requests break in non-FIFO mode. Bits 1 to 3 act only in the cycle of the write.

Top module: `vuart_lsr`

## Requirements
- R1: After a synchronous reset the status byte reads 00h. Both queues are empty, the mode is non-FIFO and the transmit-holding enable is 0.
- R2: In non-FIFO mode, a firmware write to offset 0 sets data-ready (bit 0) and a host read of offset 0 clears it. A second firmware write while the byte is still unread is ignored, so the host reads the first byte.
- R3: In FIFO mode, data-ready is 1 exactly when the receive queue is not empty. The queue keeps 16 bytes in order and ignores a 17th write.
- R4: A firmware control write with bit 1 set raises overrun (bit 1). A host status read returns the byte with overrun still 1, and the bit is 0 from the next cycle.
- R5: Parity error (bit 2) and framing error (bit 3) always read 0.
- R6: Break (bit 4) is raised in FIFO mode only by control bit 2, and in non-FIFO mode only by control bit 3. A host status read clears it.
- R7: In non-FIFO mode with the enable set, a host write to offset 0 clears transmit-holding-empty (bit 5), and a firmware read of offset 0 sets it again.
- R8: In FIFO mode with the enable set, bit 5 is 1 exactly when the transmit queue is empty. The transmit queue keeps 16 bytes in order.
- R9: While the transmit-holding enable is 0, bits 5 and 6 read 0. Transmitter-empty (bit 6) always equals bit 5.
- R10: A host write to offset 2 that changes the mode flushes both queues, so bit 5 reads 1 if enabled and bit 0 reads 0. A write that keeps the same mode flushes nothing.
- R11: Receive-FIFO-error (bit 7) reads 0 in non-FIFO mode and equals break in FIFO mode.
- R12: When a firmware set request and a host status read fall in the same cycle, the flag is 1 afterwards.
- R13: A read of an empty queue leaves the queue unchanged, and later bytes still arrive in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (host reset or power-state return) |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects at the clock edge) |
| h_addr | input | 3 | Host register offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| f_wr | input | 1 | Firmware write strobe |
| f_rd | input | 1 | Firmware read strobe |
| f_addr | input | 2 | Firmware register offset |
| f_wdata | input | 8 | Firmware write data |
| f_rdata | output | 8 | Firmware read data, combinational from f_addr |

## Verification
The hardest case to reach from the ports is a clear and a set landing in the same cycle. A host status read has to coincide exactly with a firmware overrun request. The bench drives both strobes in one cycle, then looks at the byte on the next cycle. The mode-dependent break routing is also awkward, because the same control write must be applied once in each mode. The vector table does this by switching modes in the middle of the sequence. The 16-entry limit and the empty-read case are reached by direct loops that overfill and overdrain each queue and then check byte order.

// File: rtl/vuart_pkg.sv
package vuart_pkg;

    // Host-side register offsets
    localparam logic [2:0] HA_DATA = 3'd0;
    localparam logic [2:0] HA_MODE = 3'd2;
    localparam logic [2:0] HA_LSR  = 3'd5;

    // Firmware-side register offsets
    localparam logic [1:0] FA_DATA = 2'd0;
    localparam logic [1:0] FA_CTRL = 2'd1;

    // Firmware control bit positions
    localparam int CB_THR_EN = 0;
    localparam int CB_OE     = 1;
    localparam int CB_BI_FF  = 2;
    localparam int CB_BI_NF  = 3;

    typedef struct packed {
        logic rxfe;
        logic temt;
        logic thre;
        logic bi;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } lsr_t;

    function automatic lsr_t make_lsr(input logic ff_mode, input logic thre_v,
                                      input logic bi_v, input logic oe_v,
                                      input logic dr_v);
        lsr_t s;
        s.rxfe = ff_mode & bi_v;
        s.temt = thre_v;
        s.thre = thre_v;
        s.bi   = bi_v;
        s.fe   = 1'b0;
        s.pe   = 1'b0;
        s.oe   = oe_v;
        s.dr   = dr_v;
        return s;
    endfunction

endpackage

// File: rtl/vuart_fifo.sv
module vuart_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt >= cap);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

endmodule

// File: rtl/vuart_lsr_bits.sv
module vuart_lsr_bits
    import vuart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ff_mode,
    input  logic thr_en,
    input  logic rx_empty,
    input  logic tx_empty,
    input  logic set_oe,
    input  logic set_bi,
    input  logic clr,
    output lsr_t lsr
);

    logic oe_q, bi_q;

    // A set request takes priority over the clear-on-read
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
            bi_q <= 1'b0;
        end else begin
            if (set_oe)   oe_q <= 1'b1;
            else if (clr) oe_q <= 1'b0;
            if (set_bi)   bi_q <= 1'b1;
            else if (clr) bi_q <= 1'b0;
        end
    end

    assign lsr = make_lsr(ff_mode, thr_en & tx_empty, bi_q, oe_q, ~rx_empty);

endmodule

// File: rtl/vuart_lsr.sv
module vuart_lsr
    import vuart_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [2:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          f_wr,
    input  logic          f_rd,
    input  logic [1:0]    f_addr,
    input  logic [DW-1:0] f_wdata,
    output logic [DW-1:0] f_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          ff_mode, thr_en;
    logic          mode_chg, ctrl_wr;
    logic [CW-1:0] cap;
    logic [DW-1:0] tx_dout, rx_dout;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          set_oe, set_bi, lsr_rd;
    lsr_t          lsr;

    assign mode_chg = h_wr && (h_addr == HA_MODE) && (h_wdata[0] != ff_mode);
    assign ctrl_wr  = f_wr && (f_addr == FA_CTRL);
    assign cap      = ff_mode ? CW'(DEPTH) : CW'(1);
    assign set_oe   = ctrl_wr && f_wdata[CB_OE];
    assign set_bi   = ctrl_wr && (ff_mode ? f_wdata[CB_BI_FF] : f_wdata[CB_BI_NF]);
    assign lsr_rd   = h_rd && (h_addr == HA_LSR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_mode <= 1'b0;
            thr_en  <= 1'b0;
        end else begin
            if (mode_chg) ff_mode <= h_wdata[0];
            if (ctrl_wr)  thr_en  <= f_wdata[CB_THR_EN];
        end
    end

    vuart_fifo #(.DEPTH(DEPTH), .W(DW)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_chg),
        .cap   (cap),
        .push  (h_wr && (h_addr == HA_DATA)),
        .din   (h_wdata),
        .pop   (f_rd && (f_addr == FA_DATA)),
        .dout  (tx_dout),
        .empty (tx_empty),
        .full  (tx_full)
    );

    vuart_fifo #(.DEPTH(DEPTH), .W(DW)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_chg),
        .cap   (cap),
        .push  (f_wr && (f_addr == FA_DATA)),
        .din   (f_wdata),
        .pop   (h_rd && (h_addr == HA_DATA)),
        .dout  (rx_dout),
        .empty (rx_empty),
        .full  (rx_full)
    );

    vuart_lsr_bits u_bits (
        .clk      (clk),
        .rst      (rst),
        .ff_mode  (ff_mode),
        .thr_en   (thr_en),
        .rx_empty (rx_empty),
        .tx_empty (tx_empty),
        .set_oe   (set_oe),
        .set_bi   (set_bi),
        .clr      (lsr_rd),
        .lsr      (lsr)
    );

    always_comb begin
        case (h_addr)
            HA_DATA: h_rdata = rx_dout;
            HA_MODE: h_rdata = {{(DW-1){1'b0}}, ff_mode};
            HA_LSR:  h_rdata = DW'(lsr);
            default: h_rdata = '0;
        endcase
    end

    always_comb begin
        case (f_addr)
            FA_DATA: f_rdata = tx_dout;
            FA_CTRL: f_rdata = {{(DW-3){1'b0}}, rx_full, tx_full, thr_en};
            default: f_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vuart_lsr_chk.sv
module vuart_lsr_chk
    import vuart_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       h_wr,
    input logic       h_rd,
    input logic [2:0] h_addr,
    input logic [7:0] h_wdata,
    input logic       f_wr,
    input logic [1:0] f_addr,
    input logic [7:0] f_wdata,
    input logic       ff_mode,
    input logic       thr_en,
    input lsr_t       lsr
);

    logic rd_lsr, req_oe, req_bi, chg;
    assign rd_lsr = h_rd && (h_addr == HA_LSR);
    assign req_oe = f_wr && (f_addr == FA_CTRL) && f_wdata[CB_OE];
    assign req_bi = f_wr && (f_addr == FA_CTRL) && (f_wdata[CB_BI_FF] || f_wdata[CB_BI_NF]);
    assign chg    = h_wr && (h_addr == HA_MODE) && (h_wdata[0] != ff_mode);

    a_r4_oe_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !req_oe) |=> !lsr.oe);

    a_r6_bi_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !req_bi) |=> !lsr.bi);

    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        req_oe |=> lsr.oe);

    a_r9_thre_gated: assert property (@(posedge clk) disable iff (rst)
        !thr_en |-> !lsr.thre);

    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        chg |=> (!lsr.dr && (lsr.thre == thr_en)));

    a_r11_rxfe_nonfifo: assert property (@(posedge clk) disable iff (rst)
        !ff_mode |-> !lsr.rxfe);

endmodule

bind vuart_lsr vuart_lsr_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_wr    (h_wr),
    .h_rd    (h_rd),
    .h_addr  (h_addr),
    .h_wdata (h_wdata),
    .f_wr    (f_wr),
    .f_addr  (f_addr),
    .f_wdata (f_wdata),
    .ff_mode (ff_mode),
    .thr_en  (thr_en),
    .lsr     (lsr)
);

// File: tb/vuart_lsr_tb.sv
module vuart_lsr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_wr = 1'b0, h_rd = 1'b0;
    logic [2:0] h_addr = 3'd0;
    logic [7:0] h_wdata = 8'd0;
    logic [7:0] h_rdata;
    logic       f_wr = 1'b0, f_rd = 1'b0;
    logic [1:0] f_addr = 2'd0;
    logic [7:0] f_wdata = 8'd0;
    logic [7:0] f_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vuart_lsr u_dut (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .f_wr(f_wr), .f_rd(f_rd), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata)
    );

    // op kinds: 0 host write, 1 host read, 2 fw write, 3 fw read
    // fields: kind[24:23] addr[22:20] data[19:12] expected status[11:4] req[3:0]
    localparam int NV = 19;
    localparam logic [24:0] VEC [NV] = '{
        {2'd2, 3'd1, 8'h01, 8'h60, 4'd9},   // R9 enable -> thre/temt
        {2'd0, 3'd0, 8'hA5, 8'h00, 4'd7},   // R7 host write clears thre
        {2'd3, 3'd0, 8'h00, 8'h60, 4'd7},   // R7 fw read sets thre
        {2'd2, 3'd0, 8'h3C, 8'h61, 4'd2},   // R2 dr set
        {2'd2, 3'd0, 8'h77, 8'h61, 4'd2},   // R2 second write ignored
        {2'd1, 3'd0, 8'h00, 8'h60, 4'd2},   // R2 host read clears dr
        {2'd2, 3'd1, 8'h03, 8'h62, 4'd4},   // R4 oe set
        {2'd1, 3'd5, 8'h00, 8'h60, 4'd4},   // R4 oe cleared by status read
        {2'd2, 3'd1, 8'h05, 8'h60, 4'd6},   // R6 fifo-mode break ignored in non-FIFO
        {2'd2, 3'd1, 8'h09, 8'h70, 4'd11},  // R11 bi set, bit7 stays 0 (R5 too)
        {2'd1, 3'd5, 8'h00, 8'h60, 4'd6},   // R6 bi cleared
        {2'd0, 3'd2, 8'h01, 8'h60, 4'd10},  // R10 enter FIFO mode
        {2'd2, 3'd1, 8'h05, 8'hF0, 4'd11},  // R11 bit7 mirrors bi in FIFO mode
        {2'd1, 3'd5, 8'h00, 8'h60, 4'd6},   // R6 clear
        {2'd2, 3'd1, 8'h09, 8'h60, 4'd6},   // R6 non-FIFO break ignored in FIFO
        {2'd2, 3'd1, 8'h00, 8'h00, 4'd9},   // R9 disabled -> 0
        {2'd0, 3'd0, 8'h11, 8'h00, 4'd9},   // R9 still 0
        {2'd2, 3'd1, 8'h01, 8'h00, 4'd8},   // R8 tx not empty
        {2'd3, 3'd0, 8'h00, 8'h60, 4'd8}    // R8 tx empty again
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic get_lsr(output logic [7:0] v);
        h_addr = 3'd5;
        #1 v = h_rdata;
    endtask

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); h_rd = 1'b1; h_addr = a;
        #1 d = h_rdata;
        @(negedge clk); h_rd = 1'b0;
    endtask

    task automatic fwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); f_wr = 1'b1; f_addr = a; f_wdata = d;
        @(negedge clk); f_wr = 1'b0;
    endtask

    task automatic frd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); f_rd = 1'b1; f_addr = a;
        #1 d = f_rdata;
        @(negedge clk); f_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        do_reset();
        get_lsr(s); chk("R1 reset status", s, 8'h00);
        fwr(2'd1, 8'h01);
        get_lsr(s); chk("R1 tx empty after reset", s, 8'h60);
        do_reset();

        // vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][24:23])
                2'd0: hwr(VEC[i][22:20], VEC[i][19:12]);
                2'd1: hrd(VEC[i][22:20], d);
                2'd2: fwr(VEC[i][21:20], VEC[i][19:12]);
                default: frd(VEC[i][21:20], d);
            endcase
            get_lsr(s);
            chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), s, VEC[i][11:4]);
        end

        // R2 data: first byte kept in non-FIFO mode
        do_reset();
        fwr(2'd0, 8'h3C); fwr(2'd0, 8'h77);
        hrd(3'd0, d); chk("R2 held byte", d, 8'h3C);
        // R7 non-FIFO tx data
        hwr(3'd0, 8'h5A); frd(2'd0, d); chk("R7 thr byte", d, 8'h5A);

        // R4 pre-clear read value, R12 set wins
        fwr(2'd1, 8'h03);
        hrd(3'd5, d); chk("R4 read returns pre-clear", d, 8'h62);
        get_lsr(s); chk("R4 cleared next cycle", s, 8'h60);
        fwr(2'd1, 8'h03);
        @(negedge clk);
        h_rd = 1'b1; h_addr = 3'd5; f_wr = 1'b1; f_addr = 2'd1; f_wdata = 8'h03;
        @(negedge clk);
        h_rd = 1'b0; f_wr = 1'b0;
        get_lsr(s); chk("R12 set beats clear", s, 8'h62);
        hrd(3'd5, d);

        // R3 receive FIFO depth and order, R13 empty read
        hwr(3'd2, 8'h01);
        for (int i = 0; i < 17; i++) fwr(2'd0, 8'(8'h40 + i));
        get_lsr(s); chk("R3 dr with data", s, 8'h61);
        for (int i = 0; i < 16; i++) begin
            hrd(3'd0, d); chk("R3 rx order", d, 8'(8'h40 + i));
        end
        get_lsr(s); chk("R3 dr after drain (17th dropped)", s, 8'h60);
        hrd(3'd0, d);
        fwr(2'd0, 8'hC3); fwr(2'd0, 8'hC4);
        hrd(3'd0, d); chk("R13 order after empty read", d, 8'hC3);
        hrd(3'd0, d); chk("R13 second byte", d, 8'hC4);

        // R8 transmit FIFO
        for (int i = 0; i < 17; i++) hwr(3'd0, 8'(8'h80 + i));
        get_lsr(s); chk("R8 thre low when filled", s, 8'h00);
        for (int i = 0; i < 16; i++) begin
            frd(2'd0, d); chk("R8 tx order", d, 8'(8'h80 + i));
        end
        get_lsr(s); chk("R8 thre after drain", s, 8'h60);

        // R10 same-mode write does not flush; change flushes
        fwr(2'd0, 8'h21); hwr(3'd0, 8'h22);
        hwr(3'd2, 8'h01);
        get_lsr(s); chk("R10 same mode keeps data", s, 8'h01);
        hwr(3'd2, 8'h00);
        get_lsr(s); chk("R10 change flushes", s, 8'h60);
        hrd(3'd0, d); chk("R10 rx flushed data", d, 8'h00);

        // R5 bits 2,3 never set
        fwr(2'd1, 8'h0B);
        get_lsr(s); chk("R5 pe/fe zero", s & 8'h0C, 8'h00);

        // R1 reset in mid-run
        fwr(2'd0, 8'h99);
        do_reset();
        get_lsr(s); chk("R1 mid-run reset", s, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule